// File: doc/BRIEF.md
# RSA Keyslot and Operand Controller

This block is the register-mapped front end of a raw modular-exponentiation engine. Software programs one of four key slots by setting its length and pushing exponent words through a write-only FIFO, fills a modulus buffer and a text buffer, and then sets a start bit. The block then hands the three operands and the key length to an external exponentiation core through a start/done handshake. When the core reports completion, the result replaces the contents of the text buffer, where software reads it back. No padding is checked; the block moves raw operands only.

Every operand is 2048 bits wide and is held as 64 words of 32 bits. Internal word 0 is the most significant word. Shorter operands are placed against the least significant end, with zeros in front. A control register selects the slot. It also sets how bus words map onto operand words: byte lanes may be swapped, and word positions may be mirrored. Each slot carries a loaded flag and a write-protect flag. Writes that arrive while an operation is running are discarded.

Top module: `rsa_kc`

## Requirements
- R1: After reset, the control word (0x000) and every slot control word (0x010 + 2·s) read 0. Every slot size word (0x011 + 2·s) reads 0x40. Every modulus and text word reads 0.
- R2: The control word is laid out as follows. Bit 0 reads the busy flag. Bits 7:4 are a slot field that is stored and read back, but only bits 5:4 choose the slot, so bits 7:6 are ignored. Bit 8 set means the byte lanes are swapped (little endian). Bit 9 set means normal word order.
- R3: Writing the control word with bit 0 set selects a slot. If that slot is loaded, bit 0 reads 1 from the next cycle on. core_start pulses for exactly one cycle. When core_done is seen, core_result is copied into the text buffer and bit 0 returns to 0.
- R4: If bit 0 is written while the selected slot is not loaded, bit 0 reads 1 for one cycle and then 0. No core_start is issued.
- R5: In a slot control word, bit 0 reads as the loaded flag and bit 1 as the write-protect flag, which is written directly. Writing 0 to bit 0 clears the loaded flag, the FIFO fill count and the slot's exponent. Writing 1 to bit 0 leaves the loaded flag unchanged.
- R6: A slot size word holds the key length in 32-bit words. Only bits 6:0 of a write are used. A value of 0 is stored as 1, and a value above 64 is stored as 64.
- R7: Each write to the FIFO (0x020) appends one exponent word to the selected slot. The first word is the most significant, and the last word lands in operand word 63. The slot becomes loaded once it has received as many words as its size. Further FIFO writes are ignored. Bit 8 swaps the bytes of FIFO words; bit 9 does not affect them.
- R8: While the selected slot is write-protected, writes to the FIFO and to the modulus buffer are ignored.
- R9: Bus word p of the modulus buffer (0x100 + p) or the text buffer (0x200 + p) maps to operand word p when bit 9 is 1, and to operand word 63 − p when bit 9 is 0. Bytes are swapped when bit 8 is 1. The mapping applies to both reads and writes.
- R10: While bit 0 reads 1, every bus write is dropped. This includes writes to the control word, the slot words, the FIFO and both buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current word address |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_start | output | 1 | One-cycle request to the exponentiation core |
| core_nwords | output | 7 | Key length of the selected slot, in words |
| core_exp | output | 2048 | Exponent operand of the selected slot |
| core_mod | output | 2048 | Modulus operand |
| core_base | output | 2048 | Text operand |
| core_done | input | 1 | Core completion strobe |
| core_result | input | 2048 | Core result, taken while core_done is high |

## Verification
A slot flag or FIFO count that has gone wrong shows up at the ports in one of two ways. The loaded bit may read back wrong on the very next read. Or a start that should run may complete in a single cycle without a core_start pulse, which is visible within two cycles. An error in the lane or word mapping shows up as soon as a buffer word is read back under a different control setting, and it is caught directly in the operands captured at core_start. A wrong end-of-operation state shows up as a busy flag that never drops, or as text contents that differ from the exclusive-or that the behavioural core applies.

// File: rtl/rsa_kc_pkg.sv
package rsa_kc_pkg;

    localparam int KC_WORD_W = 32;
    localparam int KC_ADDR_W = 10;

    // word-address map
    localparam logic [KC_ADDR_W-1:0] KC_CTRL_A = 10'h000;
    localparam logic [KC_ADDR_W-1:0] KC_SLOT_A = 10'h010;
    localparam logic [KC_ADDR_W-1:0] KC_FIFO_A = 10'h020;
    localparam logic [1:0]           KC_MOD_PG = 2'd1;
    localparam logic [1:0]           KC_TXT_PG = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NOP  = 2'd1,
        ST_RUN  = 2'd2
    } kc_state_e;

    function automatic logic [KC_WORD_W-1:0] lane_swap(input logic [KC_WORD_W-1:0] w);
        logic [KC_WORD_W-1:0] r;
        for (int b = 0; b < KC_WORD_W/8; b++)
            r[8*b +: 8] = w[KC_WORD_W-8-8*b +: 8];
        return r;
    endfunction

endpackage

// File: rtl/rsa_kc_opbuf.sv
module rsa_kc_opbuf #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int OP_W  = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              load,
    input  logic [OP_W-1:0]   load_op,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata,
    output logic [OP_W-1:0]   op
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            for (int w = 0; w < WORDS; w++)
                buf_d.mem[w] = load_op[OP_W-1-w*WORD_W -: WORD_W];
        end else if (we) begin
            buf_d.mem[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rdata = buf_q.mem[ridx];

    // operand word 0 is the most significant
    for (genvar w = 0; w < WORDS; w++) begin : g_op
        assign op[OP_W-1-w*WORD_W -: WORD_W] = buf_q.mem[w];
    end

endmodule

// File: rtl/rsa_kc_slots.sv
module rsa_kc_slots #(
    parameter int SLOTS  = 4,
    parameter int WORDS  = 64,
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(SLOTS),
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = IDX_W + 1,
    localparam int OP_W  = WORDS * WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        ctl_we,
    input  logic                        size_we,
    input  logic [SEL_W-1:0]            reg_slot,
    input  logic [1:0]                  ctl_wdata,
    input  logic [CNT_W-1:0]            size_wdata,
    input  logic                        fifo_we,
    input  logic [WORD_W-1:0]           fifo_wdata,
    output logic [SLOTS-1:0]            loaded,
    output logic [SLOTS-1:0]            prot,
    output logic [SLOTS-1:0][CNT_W-1:0] sizes,
    output logic [OP_W-1:0]             exp_op
);

    typedef struct packed {
        logic [SLOTS-1:0]                     loaded;
        logic [SLOTS-1:0]                     prot;
        logic [SLOTS-1:0][CNT_W-1:0]          size;
        logic [SLOTS-1:0][CNT_W-1:0]          fill;
        logic [SLOTS-1:0][WORDS-1:0][WORD_W-1:0] mem;
    } slot_t;

    slot_t sl_d, sl_q;
    logic [CNT_W-1:0] pos;

    always_comb begin
        sl_d = sl_q;
        pos  = CNT_W'(WORDS) - sl_q.size[sel] + sl_q.fill[sel];
        if (ctl_we) begin
            sl_d.prot[reg_slot] = ctl_wdata[1];
            if (!ctl_wdata[0]) begin
                sl_d.loaded[reg_slot] = 1'b0;
                sl_d.fill[reg_slot]   = '0;
                sl_d.mem[reg_slot]    = '0;
            end
        end
        if (size_we) begin
            if (size_wdata == '0)
                sl_d.size[reg_slot] = CNT_W'(1);
            else if (size_wdata > CNT_W'(WORDS))
                sl_d.size[reg_slot] = CNT_W'(WORDS);
            else
                sl_d.size[reg_slot] = size_wdata;
        end
        if (fifo_we && !sl_q.prot[sel] && !sl_q.loaded[sel]
                && sl_q.fill[sel] < sl_q.size[sel]) begin
            sl_d.mem[sel][pos[IDX_W-1:0]] = fifo_wdata;
            sl_d.fill[sel] = sl_q.fill[sel] + 1'b1;
            if (sl_q.fill[sel] + 1'b1 >= sl_q.size[sel])
                sl_d.loaded[sel] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sl_q <= '{loaded: '0, prot: '0, size: {SLOTS{CNT_W'(WORDS)}},
                      fill: '0, mem: '0};
        else
            sl_q <= sl_d;
    end

    assign loaded = sl_q.loaded;
    assign prot   = sl_q.prot;
    assign sizes  = sl_q.size;

    for (genvar w = 0; w < WORDS; w++) begin : g_exp
        assign exp_op[OP_W-1-w*WORD_W -: WORD_W] = sl_q.mem[sel][w];
    end

endmodule

// File: rtl/rsa_kc.sv
module rsa_kc
    import rsa_kc_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int WORDS = 64,
    localparam int SEL_W = $clog2(SLOTS),
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = IDX_W + 1,
    localparam int OP_W  = WORDS * KC_WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [KC_ADDR_W-1:0]  bus_addr,
    input  logic [KC_WORD_W-1:0]  bus_wdata,
    output logic [KC_WORD_W-1:0]  bus_rdata,
    output logic                  core_start,
    output logic [CNT_W-1:0]      core_nwords,
    output logic [OP_W-1:0]       core_exp,
    output logic [OP_W-1:0]       core_mod,
    output logic [OP_W-1:0]       core_base,
    input  logic                  core_done,
    input  logic [OP_W-1:0]       core_result
);

    typedef struct packed {
        kc_state_e  st;
        logic [3:0] field;
        logic       little;
        logic       normal;
        logic       start;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                       busy, wr_ok;
    logic [SEL_W-1:0]           sel;
    logic [KC_ADDR_W-1:0]       slot_off;
    logic                       slot_hit, fifo_hit, mod_hit, txt_hit, ctrl_hit;
    logic [SEL_W-1:0]           slot_idx;
    logic [IDX_W-1:0]           pidx, iidx;
    logic [KC_WORD_W-1:0]       wdata_x, mod_rd, txt_rd;
    logic [SLOTS-1:0]           slot_loaded, slot_prot;
    logic [SLOTS-1:0][CNT_W-1:0] slot_size;
    logic                       txt_load;

    // ---------------- address decode and lane mapping ----------------
    assign busy     = (ctl_q.st != ST_IDLE);
    assign wr_ok    = bus_we && !busy;
    assign sel      = ctl_q.field[SEL_W-1:0];
    assign ctrl_hit = (bus_addr == KC_CTRL_A);
    assign fifo_hit = (bus_addr == KC_FIFO_A);
    assign slot_off = bus_addr - KC_SLOT_A;
    assign slot_hit = (bus_addr >= KC_SLOT_A) && (slot_off < KC_ADDR_W'(2*SLOTS));
    assign slot_idx = slot_off[SEL_W:1];
    assign mod_hit  = (bus_addr[9:8] == KC_MOD_PG) && ({1'b0, bus_addr[7:0]} < 9'(WORDS));
    assign txt_hit  = (bus_addr[9:8] == KC_TXT_PG) && ({1'b0, bus_addr[7:0]} < 9'(WORDS));
    assign pidx     = bus_addr[IDX_W-1:0];
    assign iidx     = ctl_q.normal ? pidx : IDX_W'(WORDS-1) - pidx;
    assign wdata_x  = ctl_q.little ? lane_swap(bus_wdata) : bus_wdata;
    assign txt_load = (ctl_q.st == ST_RUN) && core_done;

    // ---------------- control next state ----------------
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_ok && ctrl_hit) begin
                    ctl_d.field  = bus_wdata[7:4];
                    ctl_d.little = bus_wdata[8];
                    ctl_d.normal = bus_wdata[9];
                    if (bus_wdata[0]) begin
                        if (slot_loaded[bus_wdata[4 +: SEL_W]]) begin
                            ctl_d.st    = ST_RUN;
                            ctl_d.start = 1'b1;
                        end else begin
                            ctl_d.st = ST_NOP;
                        end
                    end
                end
            end
            ST_NOP:  ctl_d.st = ST_IDLE;
            ST_RUN:  if (core_done) ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, field: '0, little: 1'b0, normal: 1'b0, start: 1'b0};
        else        ctl_q <= ctl_d;
    end

    // ---------------- storage ----------------
    rsa_kc_slots #(.SLOTS(SLOTS), .WORDS(WORDS), .WORD_W(KC_WORD_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .ctl_we     (wr_ok && slot_hit && !slot_off[0]),
        .size_we    (wr_ok && slot_hit && slot_off[0]),
        .reg_slot   (slot_idx),
        .ctl_wdata  (bus_wdata[1:0]),
        .size_wdata (bus_wdata[CNT_W-1:0]),
        .fifo_we    (wr_ok && fifo_hit),
        .fifo_wdata (wdata_x),
        .loaded     (slot_loaded),
        .prot       (slot_prot),
        .sizes      (slot_size),
        .exp_op     (core_exp)
    );

    rsa_kc_opbuf #(.WORDS(WORDS), .WORD_W(KC_WORD_W)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok && mod_hit && !slot_prot[sel]),
        .widx    (iidx),
        .wdata   (wdata_x),
        .load    (1'b0),
        .load_op ('0),
        .ridx    (iidx),
        .rdata   (mod_rd),
        .op      (core_mod)
    );

    rsa_kc_opbuf #(.WORDS(WORDS), .WORD_W(KC_WORD_W)) u_txt (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok && txt_hit),
        .widx    (iidx),
        .wdata   (wdata_x),
        .load    (txt_load),
        .load_op (core_result),
        .ridx    (iidx),
        .rdata   (txt_rd),
        .op      (core_base)
    );

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit)
            bus_rdata = KC_WORD_W'({ctl_q.normal, ctl_q.little, ctl_q.field, 3'b000, busy});
        else if (slot_hit && !slot_off[0])
            bus_rdata = KC_WORD_W'({slot_prot[slot_idx], slot_loaded[slot_idx]});
        else if (slot_hit)
            bus_rdata = KC_WORD_W'(slot_size[slot_idx]);
        else if (mod_hit)
            bus_rdata = ctl_q.little ? lane_swap(mod_rd) : mod_rd;
        else if (txt_hit)
            bus_rdata = ctl_q.little ? lane_swap(txt_rd) : txt_rd;
    end

    assign core_start  = ctl_q.start;
    assign core_nwords = slot_size[sel];

    logic unused_ok;
    assign unused_ok = ^{bus_wdata[KC_WORD_W-1:10], bus_wdata[3:2], bus_wdata[CNT_W-1:0]};

endmodule

// File: rtl/rsa_kc_chk.sv
module rsa_kc_chk #(
    parameter int SLOTS = 4,
    parameter int OP_W  = 2048,
    localparam int SEL_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [9:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             busy,
    input logic [SEL_W-1:0] sel,
    input logic [SLOTS-1:0] loaded,
    input logic [SLOTS-1:0] prot,
    input logic             core_start,
    input logic [OP_W-1:0]  core_mod,
    input logic [OP_W-1:0]  core_exp
);

    logic start_req, start_nokey;
    assign start_req   = bus_we && (bus_addr == 10'h000) && bus_wdata[0] && !busy;
    assign start_nokey = start_req && !loaded[bus_wdata[4 +: SEL_W]];

    // R3: the core request lasts one cycle
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R3: a request is only raised while busy
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> busy);

    // R4: no request for a slot without a key
    p_start_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> loaded[sel]);

    // R4: start on an unloaded slot is busy for exactly one cycle
    p_nokey_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_nokey |=> (busy && !core_start) ##1 !busy);

    // R8: protected slot keeps its modulus
    p_wp_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[9:8] == 2'd1 && prot[sel]) |=> $stable(core_mod));

    // R8: protected slot keeps its exponent
    p_wp_fifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 10'h020 && prot[sel]) |=> $stable(core_exp));

    // R10: writes during an operation leave the operands alone
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> ($stable(core_mod) && $stable(core_exp)));

endmodule

bind rsa_kc rsa_kc_chk #(.SLOTS(SLOTS), .OP_W(OP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .sel        (sel),
    .loaded     (slot_loaded),
    .prot       (slot_prot),
    .core_start (core_start),
    .core_mod   (core_mod),
    .core_exp   (core_exp)
);

// File: tb/sim_rsa_kc.sv
`timescale 1ns/1ps
module sim_rsa_kc;

    localparam int OP_W = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_we = 1'b0;
    logic [9:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             core_start;
    logic [6:0]       core_nwords;
    logic [OP_W-1:0]  core_exp, core_mod, core_base;
    logic             core_done = 1'b0;
    logic [OP_W-1:0]  core_result = '0;

    always #2.5 clk = ~clk;

    rsa_kc u0 (.*);

    // ---------------- behavioural exponentiation core ----------------
    logic [OP_W-1:0] cap_exp, cap_mod, cap_base;
    int starts = 0;
    int dly = 0;
    always @(negedge clk) begin
        core_done <= 1'b0;
        if (core_start) begin
            cap_exp  <= core_exp;
            cap_mod  <= core_mod;
            cap_base <= core_base;
            starts   <= starts + 1;
            dly      <= 3;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) begin
                core_done   <= 1'b1;
                core_result <= cap_base ^ cap_mod ^ cap_exp;
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chkw(input string tag, input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // call at a falling edge; returns at the next one
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            rd(10'h000, v);
            if (!v[0]) break;
        end
    endtask

    // ---------------- register vectors ----------------
    typedef struct packed {
        logic        we;
        logic [9:0]  a;
        logic [31:0] d;     // write data, or expected read data
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VT [17] = '{
        '{1'b0, 10'h000, 32'h0000_0000, 4'd1},   // R1 control
        '{1'b0, 10'h010, 32'h0000_0000, 4'd1},   // R1 slot 0 control
        '{1'b0, 10'h011, 32'h0000_0040, 4'd1},   // R1 slot 0 size
        '{1'b0, 10'h017, 32'h0000_0040, 4'd1},   // R1 slot 3 size
        '{1'b0, 10'h13F, 32'h0000_0000, 4'd1},   // R1 modulus
        '{1'b0, 10'h200, 32'h0000_0000, 4'd1},   // R1 text
        '{1'b1, 10'h000, 32'h0000_03E0, 4'd2},
        '{1'b0, 10'h000, 32'h0000_03E0, 4'd2},   // R2 fields read back
        '{1'b1, 10'h013, 32'h0000_0000, 4'd6},
        '{1'b0, 10'h013, 32'h0000_0001, 4'd6},   // R6 zero -> 1
        '{1'b1, 10'h013, 32'h0000_007F, 4'd6},
        '{1'b0, 10'h013, 32'h0000_0040, 4'd6},   // R6 clamp to 64
        '{1'b1, 10'h013, 32'h0000_0085, 4'd6},
        '{1'b0, 10'h013, 32'h0000_0005, 4'd6},   // R6 bits 6:0 only
        '{1'b1, 10'h012, 32'h0000_0003, 4'd5},
        '{1'b0, 10'h012, 32'h0000_0002, 4'd5},   // R5 writing 1 to bit 0 sets nothing
        '{1'b1, 10'h013, 32'h0000_0004, 4'd6}
    };

    localparam logic [31:0] E0 = 32'hA0A1A2A3, E1 = 32'hB0B1B2B3,
                            E2 = 32'hC0C1C2C3, E3 = 32'hD0D1D2D3;
    localparam logic [31:0] M63 = 32'h1357_9BDF, M10 = 32'h2468_ACE0, T63 = 32'h0F0E_0D0C;

    initial begin
        logic [31:0] v;
        logic [OP_W-1:0] exp_e, exp_m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 17; i++) begin
            if (VT[i].we) wr(VT[i].a, VT[i].d);
            else begin
                rd(VT[i].a, v);
                chk($sformatf("R%0d vector %0d", VT[i].rq, i), v, VT[i].d);
            end
        end
        wr(10'h012, 32'h0);                       // slot 1: unprotect

        // ---- R7/R9/R3: load slot 1 and run ----
        wr(10'h000, 32'h0000_0210);               // normal order, big endian, slot 1
        wr(10'h020, E0); wr(10'h020, E1); wr(10'h020, E2);
        rd(10'h012, v); chk("R7 not loaded after 3 of 4", v, 32'h0);
        wr(10'h020, E3);
        rd(10'h012, v); chk("R7 loaded after 4 of 4", v, 32'h1);
        wr(10'h020, 32'hBADBAD00);                // beyond size: ignored
        wr(10'h13F, M63); wr(10'h10A, M10); wr(10'h23F, T63);
        rd(10'h10A, v); chk("R9 normal big readback", v, M10);
        wr(10'h000, 32'h0000_0211);
        #1 chk("R3 busy after start", {31'b0, bus_rdata[0]}, 32'h1);
        wait_idle();
        chk("R3 one core request", starts, 1);
        exp_e = '0; exp_e[127:0] = {E0, E1, E2, E3};
        chkw("R7 exponent operand end-aligned", cap_exp, exp_e);
        exp_m = '0; exp_m[31:0] = M63; exp_m[OP_W-1-10*32 -: 32] = M10;
        chkw("R9 modulus operand", cap_mod, exp_m);
        rd(10'h23F, v); chk("R3 result word 63", v, T63 ^ M63 ^ E3);
        rd(10'h20A, v); chk("R3 result word 10", v, M10);

        // ---- R2: bits 7:6 of the slot field ignored ----
        wr(10'h000, 32'h0000_02D1);
        wait_idle();
        chk("R2 field 0xD runs slot 1", starts, 2);
        rd(10'h000, v); chk("R2 field readback", v, 32'h0000_02D0);
        rd(10'h23F, v); chk("R2 second result word 63", v, T63);

        // ---- R4: start on unloaded slot 0 ----
        wr(10'h000, 32'h0000_0201);
        #1 chk("R4 busy first cycle", {31'b0, bus_rdata[0]}, 32'h1);
        @(negedge clk);
        #1 chk("R4 idle next cycle", {31'b0, bus_rdata[0]}, 32'h0);
        repeat (5) @(negedge clk);
        chk("R4 no core request", starts, 2);

        // ---- R9: reversed order and lane swap ----
        wr(10'h000, 32'h0000_0110);
        wr(10'h100, 32'h1122_3344);
        rd(10'h100, v); chk("R9 reversed little readback", v, 32'h1122_3344);
        wr(10'h000, 32'h0000_0210);
        rd(10'h13F, v); chk("R9 mirrored word swapped", v, 32'h4433_2211);
        rd(10'h100, v); chk("R9 word 0 untouched", v, 32'h0);

        // ---- R10: writes dropped while busy ----
        wr(10'h000, 32'h0000_0211);
        wr(10'h13F, 32'hDEAD_BEEF);
        wr(10'h000, 32'h0000_0200);
        wait_idle();
        rd(10'h13F, v); chk("R10 modulus write dropped", v, 32'h4433_2211);
        rd(10'h000, v); chk("R10 control write dropped", v, 32'h0000_0210);
        chk("R10 run did start", starts, 3);

        // ---- R8: write protect ----
        wr(10'h012, 32'h3);
        rd(10'h012, v); chk("R8 protect kept loaded", v, 32'h3);
        wr(10'h13F, 32'h0000_0055);
        rd(10'h13F, v); chk("R8 modulus write ignored", v, 32'h4433_2211);
        wr(10'h014, 32'h2); wr(10'h015, 32'h1);
        wr(10'h000, 32'h0000_0220);
        wr(10'h020, 32'h77);
        rd(10'h014, v); chk("R8 fifo write ignored", v, 32'h2);
        wr(10'h014, 32'h0);
        wr(10'h020, 32'h77);
        rd(10'h014, v); chk("R7 size-1 slot loaded", v, 32'h1);

        // ---- R5: clearing a slot ----
        wr(10'h012, 32'h0);
        rd(10'h012, v); chk("R5 loaded cleared", v, 32'h0);
        wr(10'h000, 32'h0000_0211);
        repeat (6) @(negedge clk);
        chk("R5 cleared slot does not run", starts, 3);

        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule